// File: doc/BRIEF.md
# Timestamped memory traffic player

This block acts as a bus master that replays a short, preloaded script of memory transactions. Each script entry holds a timestamp, a direction flag (read or write) and a byte address. The entries are written into a small internal table through a write port. A start pulse launches playback. The player then presents the entries one at a time, strictly in table order, on a valid/ready request interface.

Two timing modes are available. In absolute mode, an entry's timestamp is a count of player clock cycles since playback began. In relative mode, the timestamp is a delay measured from the completion of the previous transaction. The first entry's delay is measured from the start of playback. Completion is signalled by a one-cycle response-done pulse. Relative mode therefore lets the issue times stretch when the memory side applies back-pressure.

A finished flag goes high once the last request has been accepted. A run with zero entries issues nothing and finishes at once.

Top module: `traffic_player`

## Requirements
- R1: After reset, `req_valid` and `finished` are low.
- R2: In absolute mode (`mode_rel`=0), an entry with timestamp N raises `req_valid` in cycle N, provided all earlier entries have been accepted by then. Cycle 0 is the first cycle after the clock edge that samples `start`.
- R3: In absolute mode, an entry whose scheduled cycle has already passed while an earlier request was stalled raises `req_valid` in the cycle right after the earlier request's handshake.
- R4: In relative mode (`mode_rel`=1), the first entry raises `req_valid` in cycle T (its timestamp). Every later entry raises it T cycles after the cycle that follows the `rsp_done` pulse for the previous request. Example: `rsp_done` high in cycle C gives `req_valid` in cycle C+1+T.
- R5: `rsp_done` has no effect when no request is awaiting its response. This covers absolute mode and the time before the first handshake. In relative mode, no new request is raised while a response is awaited.
- R6: Requests carry, in table order, each entry's address on `req_addr` and its direction on `req_write` (1 = write, 0 = read). Exactly as many handshakes occur as the sampled entry count.
- R7: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_write` hold their values.
- R8: `finished` rises in the cycle after the last entry's handshake. `req_valid` stays low while `finished` is high. The next start pulse clears `finished`.
- R9: With an entry count of zero, no request is raised and `finished` is high from cycle 0.
- R10: `mode_rel` and `entry_cnt` are sampled at the start pulse. Changing them during a run affects neither the timing mode nor the number of requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_en | input | 1 | Write one table entry |
| load_idx | input | IDX_W | Table slot to write |
| load_stamp | input | TS_W | Timestamp of the entry |
| load_write | input | 1 | Direction of the entry, 1 = write |
| load_addr | input | ADDR_W | Byte address of the entry |
| start | input | 1 | Start pulse, ignored while a run is active |
| mode_rel | input | 1 | Timing mode: 0 absolute, 1 relative |
| entry_cnt | input | CNT_W | Number of table entries to play |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted when high with valid |
| req_write | output | 1 | Request direction, 1 = write |
| req_addr | output | ADDR_W | Request byte address |
| rsp_done | input | 1 | One-cycle completion pulse for the outstanding request |
| finished | output | 1 | All requested entries handed over |

## Verification
The bench targets several timing corner cases, each with a distinct failure signature:
- Timestamps that coincide or expire during a stall. A design that dropped or reordered late entries would lose handshakes or deliver the wrong addresses. A design that waited for the timestamp to recur would hang.
- Relative delays following a response that arrives several cycles after acceptance. An off-by-one in where the delay restarts shows up as every later request landing a cycle early or late.
- A stray `rsp_done` pulse before any request. A design that honoured it would shift the first relative issue time.
- A run with zero entries, which would otherwise issue a request from an empty table.
- Mode and count inputs altered right after start. A design that read them live would switch timing rules or play an extra entry.

// File: rtl/tplay_pkg.sv
package tplay_pkg;

  // Timestamp comparison shared by both timing modes.
  function automatic logic stamp_reached(input logic [31:0] elapsed,
                                         input logic [31:0] stamp);
    return elapsed >= stamp;
  endfunction

  // Saturating increment so an idle counter never wraps back below a stamp.
  function automatic logic [31:0] bump_sat(input logic [31:0] value,
                                           input logic [31:0] ceiling);
    return (value >= ceiling) ? value : value + 32'd1;
  endfunction

  // True when the entry at position idx is the final one of the run.
  function automatic logic is_final(input logic [31:0] idx,
                                    input logic [31:0] count);
    return (idx + 32'd1) == count;
  endfunction

endpackage

// File: rtl/tplay_table.sv
module tplay_table #(
  parameter int DEPTH  = 8,
  parameter int TS_W   = 16,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TS_W-1:0]   wr_stamp,
  input  logic              wr_dir,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [TS_W-1:0]   rd_stamp,
  output logic              rd_dir,
  output logic [ADDR_W-1:0] rd_addr
);

  logic [TS_W-1:0]   stamp_q [DEPTH];
  logic              dir_q   [DEPTH];
  logic [ADDR_W-1:0] addr_q  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stamp_q[g] <= '0;
        dir_q[g]   <= 1'b0;
        addr_q[g]  <= '0;
      end else if (hit) begin
        stamp_q[g] <= wr_stamp;
        dir_q[g]   <= wr_dir;
        addr_q[g]  <= wr_addr;
      end
    end
  end

  assign rd_stamp = stamp_q[rd_idx];
  assign rd_dir   = dir_q[rd_idx];
  assign rd_addr  = addr_q[rd_idx];

endmodule

// File: rtl/tplay_timer.sv
module tplay_timer #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  output logic [TS_W-1:0] tick
);
  import tplay_pkg::*;

  localparam logic [TS_W-1:0] TICK_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tick <= '0;
    else if (clear) tick <= '0;
    else            tick <= TS_W'(bump_sat(32'(tick), 32'(TICK_MAX)));
  end

endmodule

// File: rtl/tplay_seq.sv
module tplay_seq #(
  parameter int TS_W  = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_rel,
  input  logic [CNT_W-1:0] entry_cnt,
  input  logic             req_ready,
  input  logic             rsp_done,
  input  logic [TS_W-1:0]  stamp,
  input  logic [TS_W-1:0]  tick,
  output logic             req_valid,
  output logic [CNT_W-1:0] idx,
  output logic             finished,
  output logic             running,
  output logic             run_rel,
  output logic [CNT_W-1:0] run_cnt,
  output logic             start_take,
  output logic             rsp_take
);
  import tplay_pkg::*;

  logic wait_rsp;
  logic due;
  logic hs_fire;
  logic last_fire;

  assign start_take = start && !running;
  assign due        = stamp_reached(32'(tick), 32'(stamp));
  assign req_valid  = running && !wait_rsp && due;
  assign hs_fire    = req_valid && req_ready;
  assign last_fire  = hs_fire && is_final(32'(idx), 32'(run_cnt));
  assign rsp_take   = rsp_done && wait_rsp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      finished <= 1'b0;
      run_rel  <= 1'b0;
      run_cnt  <= '0;
      idx      <= '0;
      wait_rsp <= 1'b0;
    end else if (start_take) begin
      running  <= (entry_cnt != '0);
      finished <= (entry_cnt == '0);
      run_rel  <= mode_rel;
      run_cnt  <= entry_cnt;
      idx      <= '0;
      wait_rsp <= 1'b0;
    end else if (last_fire) begin
      running  <= 1'b0;
      finished <= 1'b1;
      idx      <= idx + 1'b1;
      wait_rsp <= 1'b0;
    end else if (hs_fire) begin
      idx      <= idx + 1'b1;
      wait_rsp <= run_rel;
    end else if (rsp_take) begin
      wait_rsp <= 1'b0;
    end
  end

endmodule

// File: rtl/traffic_player.sv
module traffic_player #(
  parameter  int DEPTH  = 8,
  parameter  int TS_W   = 16,
  parameter  int ADDR_W = 32,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [IDX_W-1:0]  load_idx,
  input  logic [TS_W-1:0]   load_stamp,
  input  logic              load_write,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              start,
  input  logic              mode_rel,
  input  logic [CNT_W-1:0]  entry_cnt,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_done,
  output logic              finished
);

  // Named internal events, also visible to the bound checker.
  logic [TS_W-1:0]  tick;
  logic [TS_W-1:0]  cur_stamp;
  logic [CNT_W-1:0] idx;
  logic             running;
  logic             run_rel;
  logic [CNT_W-1:0] run_cnt;
  logic             start_take;
  logic             rsp_take;
  logic             timer_clear;

  assign timer_clear = start_take || rsp_take;

  tplay_table #(
    .DEPTH(DEPTH), .TS_W(TS_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (load_en),
    .wr_idx   (load_idx),
    .wr_stamp (load_stamp),
    .wr_dir   (load_write),
    .wr_addr  (load_addr),
    .rd_idx   (idx[IDX_W-1:0]),
    .rd_stamp (cur_stamp),
    .rd_dir   (req_write),
    .rd_addr  (req_addr)
  );

  tplay_timer #(.TS_W(TS_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (timer_clear),
    .tick  (tick)
  );

  tplay_seq #(.TS_W(TS_W), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode_rel   (mode_rel),
    .entry_cnt  (entry_cnt),
    .req_ready  (req_ready),
    .rsp_done   (rsp_done),
    .stamp      (cur_stamp),
    .tick       (tick),
    .req_valid  (req_valid),
    .idx        (idx),
    .finished   (finished),
    .running    (running),
    .run_rel    (run_rel),
    .run_cnt    (run_cnt),
    .start_take (start_take),
    .rsp_take   (rsp_take)
  );

endmodule

// File: rtl/tplay_checker.sv
module tplay_checker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_wr,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_done,
  input logic              finished,
  input logic              start_take,
  input logic              running,
  input logic              run_rel,
  input logic [CNT_W-1:0]  run_cnt
);

  logic             outstanding;
  logic [CNT_W:0]   seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding <= 1'b0;
      seen        <= '0;
    end else if (start_take) begin
      outstanding <= 1'b0;
      seen        <= '0;
    end else if (req_valid && req_ready) begin
      outstanding <= run_rel;
      seen        <= seen + 1'b1;
    end else if (rsp_done) begin
      outstanding <= 1'b0;
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_wr)));

  assert_wait_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !req_valid);

  assert_quiet_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    finished |-> !req_valid);

  assert_finish_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(finished) |-> (seen == {1'b0, run_cnt}));

  assert_tally_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seen <= {1'b0, run_cnt});

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !req_valid);

endmodule

bind traffic_player tplay_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_tplay_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_wr     (req_write),
  .req_addr   (req_addr),
  .rsp_done   (rsp_done),
  .finished   (finished),
  .start_take (start_take),
  .running    (running),
  .run_rel    (run_rel),
  .run_cnt    (run_cnt)
);

// File: tb/test_traffic_player.sv
`timescale 1ns/1ps
module test_traffic_player;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [2:0]  load_idx = '0;
  logic [15:0] load_stamp = '0;
  logic        load_write = 1'b0;
  logic [31:0] load_addr = '0;
  logic        start = 1'b0;
  logic        mode_rel = 1'b0;
  logic [3:0]  entry_cnt = '0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic        req_write;
  logic [31:0] req_addr;
  logic        rsp_done = 1'b0;
  logic        finished;

  int total = 0;
  int bad = 0;
  bit reported = 0;

  int tab_ts [8];
  bit tab_wr [8];
  int unsigned tab_addr [8];

  int rise [8];
  int hs [8];
  int unsigned got_addr [8];
  bit got_wr [8];
  int n_hs;
  int fin_c;

  always #10 clk = ~clk;

  traffic_player i_traffic_player (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_idx(load_idx),
    .load_stamp(load_stamp), .load_write(load_write), .load_addr(load_addr),
    .start(start), .mode_rel(mode_rel), .entry_cnt(entry_cnt),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .rsp_done(rsp_done), .finished(finished)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load(input int i, input int ts, input bit wr, input int unsigned addr);
    @(negedge clk);
    load_en = 1'b1; load_idx = 3'(i); load_stamp = 16'(ts);
    load_write = wr; load_addr = addr;
    tab_ts[i] = ts; tab_wr[i] = wr; tab_addr[i] = addr;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  // Drives one run: stall = ready-low cycles per request, lat = cycles from
  // handshake to rsp_done, spur = cycle of an unsolicited rsp_done (-1: none).
  // Mode and count are deliberately altered right after the start pulse (R10).
  task automatic play(input bit rel, input int cnt, input int stall, input int lat,
                      input int spur, input int maxc);
    int k = 0;
    int st = 0;
    int rsp_at = -1;
    for (int i = 0; i < 8; i++) begin rise[i] = -1; hs[i] = -1; end
    fin_c = -1;
    @(negedge clk);
    mode_rel = rel; entry_cnt = 4'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0; mode_rel = !rel; entry_cnt = 4'(cnt + 1);
    chk("R8 finished cleared by start", finished, (cnt == 0) ? 1 : 0);
    for (int c = 0; c < maxc; c++) begin
      rsp_done = (c == rsp_at) || (c == spur);
      req_ready = 1'b0;
      if (finished && fin_c < 0) fin_c = c;
      if (finished && req_valid) chk("R8 request after finished", 1, 0);
      if (req_valid && k < 8) begin
        if (rise[k] < 0) rise[k] = c;
        if (st < stall) st++;
        else begin
          req_ready = 1'b1;
          hs[k] = c; got_addr[k] = req_addr; got_wr[k] = req_write;
          k++; st = 0;
          rsp_at = c + lat;
        end
      end
      @(negedge clk);
    end
    req_ready = 1'b0; rsp_done = 1'b0;
    n_hs = k;
  endtask

  // Independent schedule model built from R2, R3 and R4.
  task automatic check_run(input string tag, input bit rel, input int cnt,
                           input int stall, input int lat);
    int prev_hs = -1;
    int exp_rise;
    chk("R6/R10 handshake count", n_hs, cnt);
    for (int k = 0; k < cnt && k < n_hs; k++) begin
      if (!rel) exp_rise = (tab_ts[k] > prev_hs + 1) ? tab_ts[k] : prev_hs + 1;
      else if (k == 0) exp_rise = tab_ts[0];
      else exp_rise = prev_hs + lat + 1 + tab_ts[k];
      chk(tag, rise[k], exp_rise);
      chk("R7 handshake after stall", hs[k], exp_rise + stall);
      chk("R6 address order", got_addr[k], tab_addr[k]);
      chk("R6 direction", got_wr[k], tab_wr[k]);
      prev_hs = exp_rise + stall;
    end
    chk("R8 finished cycle", fin_c, prev_hs + 1);
  endtask

  task automatic t_reset;
    chk("R1 req_valid after reset", req_valid, 0);
    chk("R1 finished after reset", finished, 0);
  endtask

  task automatic t_abs_plain;
    load(0, 3, 1'b0, 32'h100);
    load(1, 7, 1'b1, 32'h200);
    load(2, 7, 1'b0, 32'h300);
    play(1'b0, 3, 0, 1, -1, 20);
    check_run("R2 absolute issue cycle", 1'b0, 3, 0, 1);
  endtask

  task automatic t_abs_stall;
    load(0, 2, 1'b1, 32'hA000);
    load(1, 4, 1'b0, 32'hA040);
    load(2, 20, 1'b1, 32'hA080);
    play(1'b0, 3, 4, 2, -1, 35);
    check_run("R3 late issue cycle", 1'b0, 3, 4, 2);
  endtask

  task automatic t_rel;
    load(0, 1, 1'b0, 32'h5000);
    load(1, 3, 1'b1, 32'h5100);
    load(2, 0, 1'b0, 32'h5200);
    play(1'b1, 3, 0, 2, 0, 25);
    check_run("R4/R5 relative issue cycle", 1'b1, 3, 0, 2);
  endtask

  task automatic t_rel_stall;
    load(0, 0, 1'b1, 32'h7000);
    load(1, 2, 1'b1, 32'h7010);
    load(2, 1, 1'b0, 32'h7020);
    load(3, 5, 1'b0, 32'h7030);
    play(1'b1, 4, 2, 3, -1, 45);
    check_run("R4 relative issue with stall", 1'b1, 4, 2, 3);
  endtask

  task automatic t_empty;
    play(1'b0, 0, 0, 1, -1, 12);
    chk("R9 no request", n_hs, 0);
    chk("R9 finished at cycle 0", fin_c, 0);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    if (!reported) begin
      reported = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_abs_plain();
    t_abs_stall();
    t_rel();
    t_rel_stall();
    t_empty();
    if (!reported) begin
      reported = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end

endmodule